// File: doc/BRIEF.md
# Logic Cluster Control Generator

This block derives the shared controls for a cluster of logic cells. Each cluster-wide control (two clocks, their two enables, two asynchronous clears, one asynchronous load, one synchronous clear, one synchronous load and one add/subtract select) picks its source from a combined bus. That bus carries an 8-bit row clock bus and a set of locally routed signals. Each pick may be inverted. Each clock is gated by its own enable through a level-sensitive enable hold, so a pair can be shut off without glitches. Every cell then picks one clock pair and one of the two clears.

The selections live in static configuration registers. They are written through a small port (write strobe, address, data) on the system clock while the cluster is idle, and writes are refused while the cluster runs. Inverting a clock source lets the cells on that pair act on the source's falling edge. Since each pair has one polarity, a cluster that needs both edges uses up both pairs. The asynchronous load is split against its data input: with load data high it acts as a preset, with load data low it acts as a clear.

Top module: `lcc_ctrl_gen`

## Requirements
- R1: After a synchronous reset every control selects source 0 non-inverted and every cell uses pair 0 and clear 0; with the row bus, local bus and load data all low, every output is low.
- R2: A write to address a (0 to 9) sets the source of control a, in the order clock0, clock1, enable0, enable1, clear0, clear1, async load, sync clear, sync load, add/subtract; data[3:0] is the source index (0 to 7 row bits, 8 to 15 local bits 0 to 7) and data[4] inverts it. A write to address 10+i sets cell i: data[0] picks pair 1 when set, data[1] picks clear 1 when set.
- R3: Configuration writes made while run_i is high leave every selection unchanged.
- R4: A cell on pair k receives only clock k gated by enable k, never the other pair's clock or enable.
- R5: While enable k is low, no cell on pair k sees a rising clock edge, and cells on the other pair are unaffected.
- R6: The enable of a pair is sampled only while that pair's (post-inversion) clock is low, so an enable change while the clock is high neither starts nor cuts the current pulse.
- R7: With a clock's invert bit set, cells on that pair see a rising edge at each falling edge of the chosen source.
- R8: Each cell's asynchronous clear follows clear 0 or clear 1 as its configuration picks.
- R9: ald_set_o is high when the async load is active and ald_data_i is high, ald_clr_o when it is active and ald_data_i is low; both are never high together.
- R10: sclr_o, sload_o and addsub_o follow their chosen sources, inverted when the invert bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset of the configuration |
| run_i | input | 1 | Cluster running; configuration writes refused while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 5 | Configuration write data |
| row_clk_i | input | 8 | Row clock bus |
| local_i | input | 8 | Locally routed control signals |
| ald_data_i | input | 1 | Async load data level |
| cell_clk_o | output | 10 | Gated clock for each cell |
| cell_aclr_o | output | 10 | Async clear for each cell |
| clus_gclk_o | output | 2 | The two gated cluster clocks |
| sclr_o | output | 1 | Synchronous clear |
| sload_o | output | 1 | Synchronous load |
| addsub_o | output | 1 | Add/subtract select |
| ald_set_o | output | 1 | Async load acting as preset |
| ald_clr_o | output | 1 | Async load acting as clear |

## Verification
The assertions check on every cycle that a gated clock is never high while its raw clock is low, that a gated clock holds steady while its raw clock stays high, that the configuration does not move while the cluster runs, that no cell clock pulses without a cluster clock, and that preset and clear from the async load never coincide. Only the scenarios can show the edge counts per cell: which cells follow which pair, that a falling source edge clocks the inverted pair, that an enable turned on in mid-pulse waits for the next pulse, and that a reassigned cell moves to the other pair.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    localparam int ROW_W     = 8;
    localparam int LOCAL_W   = 8;
    localparam int NUM_CELLS = 10;
    localparam int NUM_PAIRS = 2;
    localparam int NUM_CTL   = 10;
    localparam int NUM_SRC   = ROW_W + LOCAL_W;
    localparam int SRC_W     = $clog2(NUM_SRC);
    localparam int CFG_DW    = SRC_W + 1;
    localparam int NUM_REG   = NUM_CTL + NUM_CELLS;
    localparam int CFG_AW    = $clog2(NUM_REG);

    typedef enum logic [3:0] {
        CTL_CLK0   = 4'd0,
        CTL_CLK1   = 4'd1,
        CTL_EN0    = 4'd2,
        CTL_EN1    = 4'd3,
        CTL_ACLR0  = 4'd4,
        CTL_ACLR1  = 4'd5,
        CTL_ALOAD  = 4'd6,
        CTL_SCLR   = 4'd7,
        CTL_SLOAD  = 4'd8,
        CTL_ADDSUB = 4'd9
    } ctl_e;

    typedef struct packed {
        logic               inv;
        logic [SRC_W-1:0]   idx;
    } src_sel_t;

    typedef struct packed {
        logic clr_sel;
        logic pair_sel;
    } cell_sel_t;

    function automatic src_sel_t unpack_src(input logic [CFG_DW-1:0] d);
        return src_sel_t'(d);
    endfunction

    function automatic cell_sel_t unpack_cell(input logic [CFG_DW-1:0] d);
        return cell_sel_t'(d[1:0]);
    endfunction

endpackage

// File: rtl/lcc_cfg_regs.sv
module lcc_cfg_regs
    import lcc_pkg::*;
#(
    parameter int N_CELLS = NUM_CELLS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run_i,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [CFG_DW-1:0]        cfg_wdata,
    output src_sel_t  [NUM_CTL-1:0]  ctl_cfg,
    output cell_sel_t [N_CELLS-1:0]  cell_cfg
);

    logic wr_ok;
    assign wr_ok = cfg_we && !run_i;

    // One register per cluster control
    for (genvar c = 0; c < NUM_CTL; c++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (rst) begin
                ctl_cfg[c] <= '0;
            end else if (wr_ok && cfg_addr == CFG_AW'(c)) begin
                ctl_cfg[c] <= unpack_src(cfg_wdata);
            end
        end
    end

    // One register per cell, placed after the control block
    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cell_cfg[i] <= '0;
            end else if (wr_ok && cfg_addr == CFG_AW'(NUM_CTL + i)) begin
                cell_cfg[i] <= unpack_cell(cfg_wdata);
            end
        end
    end

endmodule

// File: rtl/lcc_src_mux.sv
module lcc_src_mux
    import lcc_pkg::*;
(
    input  logic [NUM_SRC-1:0] src_bus,
    input  src_sel_t           sel,
    output logic               y
);

    logic picked;

    always_comb begin
        if (int'(sel.idx) < NUM_SRC) begin
            picked = src_bus[sel.idx];
        end else begin
            picked = 1'b0;
        end
        y = picked ^ sel.inv;
    end

endmodule

// File: rtl/lcc_clk_gate.sv
module lcc_clk_gate (
    input  logic raw_clk,
    input  logic en,
    output logic gclk
);

    logic en_hold;

    // Enable passes only while the clock is low, frozen while it is high
    always_latch begin
        if (!raw_clk) begin
            en_hold = en;
        end
    end

    assign gclk = raw_clk & en_hold;

endmodule

// File: rtl/lcc_cell_fanout.sv
module lcc_cell_fanout
    import lcc_pkg::*;
#(
    parameter int N_CELLS = NUM_CELLS
) (
    input  logic [NUM_PAIRS-1:0]     gclk,
    input  logic [1:0]               aclr,
    input  cell_sel_t [N_CELLS-1:0]  cell_cfg,
    output logic [N_CELLS-1:0]       cell_clk,
    output logic [N_CELLS-1:0]       cell_aclr
);

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        always_comb begin
            cell_clk[i]  = cell_cfg[i].pair_sel ? gclk[1] : gclk[0];
            cell_aclr[i] = cell_cfg[i].clr_sel  ? aclr[1] : aclr[0];
        end
    end

endmodule

// File: rtl/lcc_ctrl_gen.sv
module lcc_ctrl_gen
    import lcc_pkg::*;
#(
    parameter int N_CELLS = NUM_CELLS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run_i,
    input  logic                    cfg_we,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [CFG_DW-1:0]       cfg_wdata,
    input  logic [ROW_W-1:0]        row_clk_i,
    input  logic [LOCAL_W-1:0]      local_i,
    input  logic                    ald_data_i,
    output logic [N_CELLS-1:0]      cell_clk_o,
    output logic [N_CELLS-1:0]      cell_aclr_o,
    output logic [NUM_PAIRS-1:0]    clus_gclk_o,
    output logic                    sclr_o,
    output logic                    sload_o,
    output logic                    addsub_o,
    output logic                    ald_set_o,
    output logic                    ald_clr_o
);

    src_sel_t  [NUM_CTL-1:0]  ctl_cfg;
    cell_sel_t [N_CELLS-1:0]  cell_cfg;
    logic [NUM_SRC-1:0]       src_bus;
    logic [NUM_CTL-1:0]       ctl_val;
    logic [NUM_PAIRS-1:0]     raw_clk;
    logic [NUM_PAIRS-1:0]     pair_en;
    logic                     aload;

    assign src_bus = {local_i, row_clk_i};

    lcc_cfg_regs #(.N_CELLS(N_CELLS)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run_i),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctl_cfg   (ctl_cfg),
        .cell_cfg  (cell_cfg)
    );

    for (genvar c = 0; c < NUM_CTL; c++) begin : g_mux
        lcc_src_mux u_mux (
            .src_bus (src_bus),
            .sel     (ctl_cfg[c]),
            .y       (ctl_val[c])
        );
    end

    assign raw_clk = {ctl_val[CTL_CLK1], ctl_val[CTL_CLK0]};
    assign pair_en = {ctl_val[CTL_EN1],  ctl_val[CTL_EN0]};

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_gate
        lcc_clk_gate u_gate (
            .raw_clk (raw_clk[k]),
            .en      (pair_en[k]),
            .gclk    (clus_gclk_o[k])
        );
    end

    lcc_cell_fanout #(.N_CELLS(N_CELLS)) u_fan (
        .gclk      (clus_gclk_o),
        .aclr      ({ctl_val[CTL_ACLR1], ctl_val[CTL_ACLR0]}),
        .cell_cfg  (cell_cfg),
        .cell_clk  (cell_clk_o),
        .cell_aclr (cell_aclr_o)
    );

    assign aload     = ctl_val[CTL_ALOAD];
    assign ald_set_o = aload &  ald_data_i;
    assign ald_clr_o = aload & ~ald_data_i;
    assign sclr_o    = ctl_val[CTL_SCLR];
    assign sload_o   = ctl_val[CTL_SLOAD];
    assign addsub_o  = ctl_val[CTL_ADDSUB];

endmodule

// File: rtl/lcc_ctrl_gen_chk.sv
module lcc_ctrl_gen_chk
    import lcc_pkg::*;
#(
    parameter int N_CELLS = NUM_CELLS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run_i,
    input  src_sel_t  [NUM_CTL-1:0] ctl_cfg,
    input  cell_sel_t [N_CELLS-1:0] cell_cfg,
    input  logic [NUM_PAIRS-1:0]    raw_clk,
    input  logic [NUM_PAIRS-1:0]    clus_gclk_o,
    input  logic [N_CELLS-1:0]      cell_clk_o,
    input  logic                    ald_set_o,
    input  logic                    ald_clr_o
);

    a_r3_run_locks_cfg: assert property (@(posedge clk) disable iff (rst)
        run_i |=> ($stable(ctl_cfg) && $stable(cell_cfg)));

    a_r9_set_clr_excl: assert property (@(posedge clk) disable iff (rst)
        !(ald_set_o && ald_clr_o));

    a_r4_cell_needs_pair: assert property (@(posedge clk) disable iff (rst)
        (|cell_clk_o) |-> (|clus_gclk_o));

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        a_r6_low_raw_low_gclk: assert property (@(posedge clk) disable iff (rst)
            !raw_clk[k] |-> !clus_gclk_o[k]);

        a_r6_hold_while_high: assert property (@(posedge clk) disable iff (rst)
            (raw_clk[k] && $past(raw_clk[k])) |-> $stable(clus_gclk_o[k]));
    end

endmodule

bind lcc_ctrl_gen lcc_ctrl_gen_chk #(.N_CELLS(N_CELLS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .run_i       (run_i),
    .ctl_cfg     (ctl_cfg),
    .cell_cfg    (cell_cfg),
    .raw_clk     (raw_clk),
    .clus_gclk_o (clus_gclk_o),
    .cell_clk_o  (cell_clk_o),
    .ald_set_o   (ald_set_o),
    .ald_clr_o   (ald_clr_o)
);

// File: tb/lcc_ctrl_gen_bench.sv
module lcc_ctrl_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 10;
    localparam int NV = 8;

    // {row[7:0], local[7:0], ald_data, exp{sclr,sload,addsub,set,clr,aclr_lo,aclr_hi}}
    localparam logic [23:0] VEC [NV] = '{
        {8'h04, 8'h00, 1'b0, 7'b1000000},
        {8'h0C, 8'h10, 1'b0, 7'b0000010},
        {8'h14, 8'h2C, 1'b1, 7'b1111001},
        {8'h1C, 8'h08, 1'b0, 7'b1100110},
        {8'h04, 8'h3C, 1'b1, 7'b0011001},
        {8'hF4, 8'hFF, 1'b0, 7'b0110101},
        {8'h0C, 8'h04, 1'b1, 7'b1000011},
        {8'h04, 8'h08, 1'b1, 7'b1001000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_i = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [4:0]  cfg_wdata = '0;
    logic [7:0]  row_clk_i = '0;
    logic [7:0]  local_i = '0;
    logic        ald_data_i = 1'b0;
    logic [NC-1:0] cell_clk_o, cell_aclr_o;
    logic [1:0]  clus_gclk_o;
    logic        sclr_o, sload_o, addsub_o, ald_set_o, ald_clr_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [NC*16-1:0] cnt_bus;
    logic [NC*16-1:0] snap;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcc_ctrl_gen u_lcc_ctrl_gen (
        .clk(clk), .rst(rst), .run_i(run_i), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .row_clk_i(row_clk_i),
        .local_i(local_i), .ald_data_i(ald_data_i), .cell_clk_o(cell_clk_o),
        .cell_aclr_o(cell_aclr_o), .clus_gclk_o(clus_gclk_o), .sclr_o(sclr_o),
        .sload_o(sload_o), .addsub_o(addsub_o), .ald_set_o(ald_set_o),
        .ald_clr_o(ald_clr_o)
    );

    for (genvar g = 0; g < NC; g++) begin : g_cnt
        logic [15:0] n = '0;
        always @(posedge cell_clk_o[g]) n <= n + 16'd1;
        assign cnt_bus[g*16 +: 16] = n;
    end

    function automatic logic [15:0] delta(input int i);
        return cnt_bus[i*16 +: 16] - snap[i*16 +: 16];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 5'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // pair 0: row bit 1, idle low; pair 1: row bit 2 inverted, idle high
    task automatic pulse(input int pair, input int times);
        for (int t = 0; t < times; t++) begin
            @(negedge clk);
            if (pair == 0) row_clk_i[1] = 1'b1; else row_clk_i[2] = 1'b0;
            @(negedge clk);
            if (pair == 0) row_clk_i[1] = 1'b0; else row_clk_i[2] = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic check_deltas(input string req, input logic [NC-1:0] mask, input int exp_n);
        for (int i = 0; i < NC; i++) begin
            check(req, 32'(delta(i)), mask[i] ? 32'(exp_n) : 32'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: reset state, everything low
        check("R1 outputs idle", {cell_clk_o, cell_aclr_o, clus_gclk_o, sclr_o, sload_o,
              addsub_o, ald_set_o, ald_clr_o}, '0);
        // R1: all controls follow row bit 0 after reset
        @(negedge clk);
        row_clk_i = 8'h01;
        #1;
        check("R1 default source", {cell_aclr_o, sclr_o, sload_o, addsub_o, ald_set_o, ald_clr_o},
              {{NC{1'b1}}, 5'b11101});
        row_clk_i = 8'h00;

        // R3: write while running is refused
        run_i = 1'b1;
        wr(7, 5);
        run_i = 1'b0;
        @(negedge clk);
        row_clk_i = 8'h20;
        #1;
        check("R3 write ignored", sclr_o, 1'b0);

        // R2: program sources and cells
        row_clk_i = 8'h04;
        wr(0, 1);
        wr(1, 5'h12);
        wr(2, 8);
        wr(3, 9);
        wr(4, 3);
        wr(5, 10);
        wr(6, 11);
        wr(7, 5'h1C);
        wr(8, 4);
        wr(9, 13);
        for (int i = 0; i < NC; i++) begin
            wr(10 + i, ((i >= 5) ? 2 : 0) | (i % 2));
        end

        // R8 R9 R10: control routing table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            row_clk_i  = VEC[v][23:16];
            local_i    = VEC[v][15:8];
            ald_data_i = VEC[v][7];
            #1;
            check("R10 sync controls", {sclr_o, sload_o, addsub_o}, VEC[v][6:4]);
            check("R9 async load split", {ald_set_o, ald_clr_o}, VEC[v][3:2]);
            check("R8 cell clears", cell_aclr_o, {{5{VEC[v][0]}}, {5{VEC[v][1]}}});
        end

        @(negedge clk);
        row_clk_i = 8'h04; local_i = 8'h03; ald_data_i = 1'b0;
        @(negedge clk);

        // R4: pair 0 pulses reach even cells only
        snap = cnt_bus;
        pulse(0, 3);
        check_deltas("R4 pair0 fanout", 10'b0101010101, 3);

        // R7: inverted pair clocks on source falling edge
        snap = cnt_bus;
        pulse(1, 2);
        check_deltas("R7 pair1 falling", 10'b1010101010, 2);
        @(negedge clk);
        row_clk_i[2] = 1'b0;
        #1;
        check("R7 gclk1 high on fall", clus_gclk_o, 2'b10);
        @(negedge clk);
        row_clk_i[2] = 1'b1;
        #1;
        check("R7 gclk1 low on rise", clus_gclk_o, 2'b00);

        // R5: enable 0 low blocks pair 0 only
        @(negedge clk);
        local_i[0] = 1'b0;
        snap = cnt_bus;
        pulse(0, 2);
        pulse(1, 1);
        check_deltas("R5 pair0 gated", 10'b1010101010, 1);

        // R6: enable raised while clock high waits for next pulse
        @(negedge clk);
        row_clk_i[1] = 1'b1;
        @(negedge clk);
        local_i[0] = 1'b1;
        #1;
        check("R6 no mid-pulse open", {clus_gclk_o[0], cell_clk_o[0]}, 2'b00);
        @(negedge clk);
        row_clk_i[1] = 1'b0;
        snap = cnt_bus;
        pulse(0, 1);
        check_deltas("R6 next pulse passes", 10'b0101010101, 1);

        // R2: move cell 0 onto pair 1
        wr(10, 1);
        snap = cnt_bus;
        pulse(1, 1);
        pulse(0, 1);
        check("R2 cell0 on pair1", 32'(delta(0)), 32'd1);
        check("R4 cell2 still pair0", 32'(delta(2)), 32'd1);
        check("R4 cell1 pair1 once", 32'(delta(1)), 32'd1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule